// File: doc/BRIEF.md
# Programmable Audio Serial Clock Generator

This block derives two audio clocks from an incoming audio master clock. The first output is a serial bit clock, produced by counting selected master-clock edges. The second output is a left/right word-select clock, produced by counting selected edges of that bit clock. The whole block runs on one fast system clock. The master clock enters as a sampled input, goes through a synchronizer, and then an edge picker turns it into single-cycle ticks. No derived clock is ever used as a clock net, so all timing stays in one domain.

Two 8-bit divider inputs set the ratios. A two-bit phase input chooses the triggering edge for each stage: bit 0 picks the master-clock edge that drives the bit clock, and bit 1 picks the bit-clock edge that drives word-select. These inputs go into shadow registers. The shadow registers load continuously while reset is held, and at run time they load only at a word-select transition. A divider change in mid-frame therefore cannot shorten any clock phase.

Top module: `audclk_gen`

## Requirements
- R1: The bit clock period equals 2×(SDIV+1) master clock periods, and its high and low phases are equal. SDIV=1 gives a division by 4 and SDIV=0 gives a division by 2.
- R2: The word-select period equals 2×LRDIV bit clock periods. Word-select toggles after every LRDIV selected bit-clock edges.
- R3: An LRDIV value of 0 behaves exactly like LRDIV=1, which gives a word-select period of 2 bit clock periods.
- R4: With phase_in[0]=1 every bit-clock transition follows a rising master-clock edge. With phase_in[0]=0 it follows a falling edge. The transition comes SYNC_STAGES+1 system cycles after the master edge is sampled, and this delay is less than half a master period.
- R5: Each word-select transition occurs in the same cycle as a bit-clock transition. With phase_in[1]=1 that transition leaves the bit clock high (a rising edge). With phase_in[1]=0 it leaves the bit clock low (a falling edge).
- R6: New divider and phase inputs take effect only at the next word-select transition. Until that transition every bit-clock half period keeps the old length, and from it onward every half period has the new length, so no runt appears.
- R7: While rst is high the bit clock and word-select are held low and both counters are cleared. The inputs present at release apply from the first transition onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be well over twice the master clock rate |
| rst | input | 1 | Synchronous reset, active high |
| mclk_in | input | 1 | Audio master clock, sampled |
| sdiv_in | input | DIV_W | Bit clock divider setting |
| lrdiv_in | input | DIV_W | Word-select divider setting |
| phase_in | input | 2 | Bit 0: bit-clock trigger edge; bit 1: word-select trigger edge (1 = rising) |
| bclk_o | output | 1 | Audio serial bit clock |
| ws_o | output | 1 | Left/right word-select clock |

## Verification
The word-select boundary is where two things coincide. A configuration commit and a bit-clock toggle with counter reload land in the same cycle. The bench provokes this by changing SDIV and LRDIV partway through a word-select half period. It then measures every bit-clock half period: each one up to and including the one that ends at the boundary must have the old length, and each one after must have the new length. A following word-select period confirms that the new LRDIV has been taken up.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

   typedef enum logic {
      EDGE_FALL = 1'b0,
      EDGE_RISE = 1'b1
   } edge_pol_e;

   localparam int PH_BCLK = 0;
   localparam int PH_WS   = 1;

   function automatic logic edge_hit(input logic cur, input logic prev, input edge_pol_e pol);
      if (pol == EDGE_RISE) return cur & ~prev;
      return ~cur & prev;
   endfunction

endpackage

// File: rtl/audclk_edge_pick.sv
module audclk_edge_pick #(
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  sig_i,
   input  audclk_pkg::edge_pol_e pol_i,
   output logic                  tick_o
);
   logic cur_w;
   logic prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign cur_w = sig_i;
      end else if (SYNC_STAGES == 1) begin : g_one
         logic s_q;
         always_ff @(posedge clk) s_q <= sig_i;
         assign cur_w = s_q;
      end else begin : g_chain
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk) chain_q <= {chain_q[SYNC_STAGES-2:0], sig_i};
         assign cur_w = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) prev_q <= cur_w;

   assign tick_o = audclk_pkg::edge_hit(cur_w, prev_q, pol_i);
endmodule

// File: rtl/audclk_cfg_shadow.sv
module audclk_cfg_shadow #(
   parameter int DIV_W = 8
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  commit_i,
   input  logic [DIV_W-1:0]      sdiv_i,
   input  logic [DIV_W-1:0]      lrdiv_i,
   input  logic [1:0]            phase_i,
   output logic [DIV_W-1:0]      sdiv_o,
   output logic [DIV_W-1:0]      lrdiv_o,
   output audclk_pkg::edge_pol_e bpol_o,
   output audclk_pkg::edge_pol_e wpol_o
);
   localparam logic [DIV_W-1:0] LR_MIN = DIV_W'(1);

   logic [DIV_W-1:0] sdiv_q;
   logic [DIV_W-1:0] lrdiv_q;
   logic [1:0]       phase_q;
   logic [DIV_W-1:0] lrdiv_fix;

   assign lrdiv_fix = (lrdiv_i == '0) ? LR_MIN : lrdiv_i;

   always_ff @(posedge clk) begin
      if (rst || commit_i) begin
         sdiv_q  <= sdiv_i;
         lrdiv_q <= lrdiv_fix;
         phase_q <= phase_i;
      end
   end

   assign sdiv_o  = sdiv_q;
   assign lrdiv_o = lrdiv_q;
   assign bpol_o  = audclk_pkg::edge_pol_e'(phase_q[audclk_pkg::PH_BCLK]);
   assign wpol_o  = audclk_pkg::edge_pol_e'(phase_q[audclk_pkg::PH_WS]);
endmodule

// File: rtl/audclk_bit_div.sv
module audclk_bit_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick_i,
   input  logic [DIV_W-1:0] limit_i,
   output logic             bclk_o,
   output logic             toggle_o
);
   logic [DIV_W-1:0] cnt_q;
   logic             lvl_q;

   assign toggle_o = tick_i && (cnt_q >= limit_i);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         lvl_q <= 1'b0;
      end else if (tick_i) begin
         if (toggle_o) begin
            cnt_q <= '0;
            lvl_q <= ~lvl_q;
         end else begin
            cnt_q <= cnt_q + DIV_W'(1);
         end
      end
   end

   assign bclk_o = lvl_q;
endmodule

// File: rtl/audclk_ws_div.sv
module audclk_ws_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick_i,
   input  logic [DIV_W-1:0] limit_i,
   output logic             ws_o,
   output logic             toggle_o,
   output logic [DIV_W-1:0] cnt_o
);
   localparam int XW = DIV_W + 1;

   logic [DIV_W-1:0] cnt_q;
   logic             lvl_q;
   logic [XW-1:0]    cnt_next;

   assign cnt_next = XW'(cnt_q) + XW'(1);
   assign toggle_o = tick_i && (cnt_next >= XW'(limit_i));

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         lvl_q <= 1'b0;
      end else if (tick_i) begin
         if (toggle_o) begin
            cnt_q <= '0;
            lvl_q <= ~lvl_q;
         end else begin
            cnt_q <= cnt_next[DIV_W-1:0];
         end
      end
   end

   assign ws_o  = lvl_q;
   assign cnt_o = cnt_q;
endmodule

// File: rtl/audclk_gen.sv
module audclk_gen #(
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             mclk_in,
   input  logic [DIV_W-1:0] sdiv_in,
   input  logic [DIV_W-1:0] lrdiv_in,
   input  logic [1:0]       phase_in,
   output logic             bclk_o,
   output logic             ws_o
);
   generate
      if (DIV_W < 2 || DIV_W > 16) begin : g_bad_width
         $error("audclk_gen: DIV_W must lie in 2..16");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("audclk_gen: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic                  mclk_tick;
   logic                  bclk_toggle;
   logic                  ws_tick;
   logic                  ws_toggle;
   logic [DIV_W-1:0]      sdiv_q;
   logic [DIV_W-1:0]      lrdiv_q;
   logic [DIV_W-1:0]      ws_cnt;
   audclk_pkg::edge_pol_e bpol;
   audclk_pkg::edge_pol_e wpol;

   audclk_cfg_shadow #(.DIV_W(DIV_W)) shadow_i (
      .clk     (clk),
      .rst     (rst),
      .commit_i(ws_toggle),
      .sdiv_i  (sdiv_in),
      .lrdiv_i (lrdiv_in),
      .phase_i (phase_in),
      .sdiv_o  (sdiv_q),
      .lrdiv_o (lrdiv_q),
      .bpol_o  (bpol),
      .wpol_o  (wpol)
   );

   audclk_edge_pick #(.SYNC_STAGES(SYNC_STAGES)) mpick_i (
      .clk   (clk),
      .sig_i (mclk_in),
      .pol_i (bpol),
      .tick_o(mclk_tick)
   );

   audclk_bit_div #(.DIV_W(DIV_W)) bdiv_i (
      .clk     (clk),
      .rst     (rst),
      .tick_i  (mclk_tick),
      .limit_i (sdiv_q),
      .bclk_o  (bclk_o),
      .toggle_o(bclk_toggle)
   );

   // the bit clock level after a toggle is ~bclk_o; count it when that matches
   assign ws_tick = bclk_toggle && ((~bclk_o) == logic'(wpol));

   audclk_ws_div #(.DIV_W(DIV_W)) wdiv_i (
      .clk     (clk),
      .rst     (rst),
      .tick_i  (ws_tick),
      .limit_i (lrdiv_q),
      .ws_o    (ws_o),
      .toggle_o(ws_toggle),
      .cnt_o   (ws_cnt)
   );
endmodule

// File: rtl/audclk_gen_chk.sv
module audclk_gen_chk #(
   parameter int DIV_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             bclk_o,
   input logic             ws_o,
   input logic             mtick,
   input logic             wtoggle,
   input logic [DIV_W-1:0] wcnt,
   input logic [DIV_W-1:0] lrdiv_q,
   input logic [DIV_W-1:0] sdiv_q
);
   // R7: reset forces both outputs low
   p_rst_low_r7: assert property (@(posedge clk) rst |=> (!bclk_o && !ws_o));

   // R4: bit clock moves only after a selected master tick
   p_bclk_tick_r4: assert property (@(posedge clk) disable iff (rst)
      (bclk_o != $past(bclk_o)) |-> $past(mtick));

   // R5: word-select moves only together with the bit clock
   p_ws_on_bclk_r5: assert property (@(posedge clk) disable iff (rst)
      (ws_o != $past(ws_o)) |-> (bclk_o != $past(bclk_o)));

   // R6: divider shadow changes only at a word-select boundary
   p_cfg_boundary_r6: assert property (@(posedge clk) disable iff (rst)
      ((sdiv_q != $past(sdiv_q)) || (lrdiv_q != $past(lrdiv_q))) |-> $past(wtoggle || rst));

   // R2, R3: word-select counter stays below the effective limit
   p_wcnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
      (lrdiv_q != '0) && (wcnt < lrdiv_q));
endmodule

bind audclk_gen audclk_gen_chk #(.DIV_W(DIV_W)) chk_i (
   .clk    (clk),
   .rst    (rst),
   .bclk_o (bclk_o),
   .ws_o   (ws_o),
   .mtick  (mclk_tick),
   .wtoggle(ws_toggle),
   .wcnt   (ws_cnt),
   .lrdiv_q(lrdiv_q),
   .sdiv_q (sdiv_q)
);

// File: tb/audclk_gen_tb_top.sv
`timescale 1ns/1ps
module audclk_gen_tb_top;
   localparam int H  = 4;        // master half period in system cycles
   localparam int MP = 2 * H;    // master period

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       mclk = 1'b0;
   logic [7:0] sdiv = 8'd3;
   logic [7:0] lrdiv = 8'd16;
   logic [1:0] ph = 2'b11;
   logic [1:0] ph_a = 2'b11;
   wire        bclk;
   wire        ws;

   int total = 0, bad = 0;
   int n = 0, mcnt = 0;
   int last_mrise = 0, last_mfall = 0;
   int last_be = 0, bhalf = 0, last_brise = 0, bper = 0;
   int last_wrise = 0, wper = 0, wedges = 0;
   int align_err = 0, hp_err = 0, hp_exp = 0;
   bit hp_on = 1'b0;
   logic bq = 1'b0, wq = 1'b0;

   always #2.5 clk = ~clk;

   audclk_gen dut_i (
      .clk(clk), .rst(rst), .mclk_in(mclk), .sdiv_in(sdiv),
      .lrdiv_in(lrdiv), .phase_in(ph), .bclk_o(bclk), .ws_o(ws)
   );

   always @(negedge clk) begin
      n++;
      if (!rst) begin
         if (bclk !== bq) begin
            bhalf = n - last_be;
            last_be = n;
            if (hp_on && bhalf != hp_exp) hp_err++;
            if (bclk === 1'b1) begin bper = n - last_brise; last_brise = n; end
            if ((n - (ph_a[0] ? last_mrise : last_mfall)) >= H) align_err++;
         end
         if (ws !== wq) begin
            wedges++;
            if (bclk === bq || bclk !== ph_a[1]) align_err++;
            if (ws === 1'b1) begin wper = n - last_wrise; last_wrise = n; end
         end
      end
      bq = bclk;
      wq = ws;
      mcnt++;
      if (mcnt == H) begin
         mcnt = 0;
         mclk = ~mclk;
         if (mclk) last_mrise = n; else last_mfall = n;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_ws(input int k);
      int s = wedges;
      while (wedges < s + k) @(posedge clk);
   endtask

   function automatic int exp_bper(input int s);
      return 2 * (s + 1) * MP;
   endfunction

   function automatic int exp_wper(input int s, input int l);
      int e = (l == 0) ? 1 : l;
      return 2 * e * exp_bper(s);
   endfunction

   task automatic run_cfg(input int s, input int l, input logic [1:0] p);
      @(negedge clk);
      rst = 1'b1; sdiv = 8'(s); lrdiv = 8'(l); ph = p; ph_a = p;
      repeat (3) @(negedge clk);
      chk(bclk === 1'b0 && ws === 1'b0, "R7 outputs low in reset", {bclk, ws}, 0);
      rst = 1'b0;
      wait_ws(1);
      align_err = 0;
      wait_ws(4);
      chk(bper == exp_bper(s), "R1 bit clock period", bper, exp_bper(s));
      chk(bhalf == exp_bper(s) / 2, "R1 bit clock half period", bhalf, exp_bper(s) / 2);
      if (l == 0) chk(wper == exp_wper(s, l), "R3 zero divider as one", wper, exp_wper(s, l));
      else        chk(wper == exp_wper(s, l), "R2 word-select period", wper, exp_wper(s, l));
      chk(align_err == 0, "R4 R5 edge alignment", align_err, 0);
   endtask

   initial begin
      int unsigned seed_v;
      seed_v = $urandom(32'd1234);
      // R1, R2: ratio examples (SDIV=3/LRDIV=16, SDIV=7/LRDIV=8, SDIV=1/LRDIV=32)
      run_cfg(3, 16, 2'b11);
      run_cfg(7, 8, 2'b01);
      run_cfg(1, 32, 2'b10);
      // R4, R5: all four phase settings
      for (int p = 0; p < 4; p++) run_cfg(2, 3, 2'(p));
      // R3: zero word-select divider
      run_cfg(1, 0, 2'b11);
      run_cfg(0, 0, 2'b00);
      // random mix
      for (int i = 0; i < 6; i++)
         run_cfg(int'($urandom_range(0, 5)), int'($urandom_range(0, 6)), 2'($urandom_range(0, 3)));
      // R6: mid-frame divider change, deferred to next boundary
      run_cfg(3, 4, 2'b11);
      wait_ws(1);
      repeat (50) @(posedge clk);
      hp_err = 0;
      hp_exp = 4 * MP;
      hp_on = 1'b1;
      sdiv = 8'd1;
      lrdiv = 8'd2;
      wait_ws(1);
      hp_exp = 2 * MP;
      repeat (200) @(posedge clk);
      hp_on = 1'b0;
      chk(hp_err == 0, "R6 no runt, change at boundary", hp_err, 0);
      wait_ws(4);
      chk(wper == exp_wper(1, 2), "R6 new word-select divider", wper, exp_wper(1, 2));
      chk(bper == exp_bper(1), "R6 new bit divider", bper, exp_bper(1));
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule